// File: doc/BRIEF.md
# Two-Phase Control-Symbol Link Trainer

This block brings a serial link up at the byte level. It sits above an 8b/10b transceiver and sees only parallel bytes: each byte carries a control flag, and a strobe marks the cycles that hold a received symbol. While it trains, the block drives a control character on the transmit side every cycle. It listens for an unbroken run of the same character coming back from the far end.

Training goes through two ordered phases. In the first phase the block sends the comma character K28.5 and waits for a run of matching symbols. In the second phase it sends K28.0 and waits for a run of that character. After the second run the link is declared up, and the transmit side carries user bytes with the control flag clear. A loss-of-sync input, or an unexpected symbol during the second phase, sends training back to the start. A phase status output and a link-up flag let the surrounding logic follow the progress.

Top module: `link_trainer`

## Requirements
- R1: After synchronous active-high reset, `phase` is 0, `link_up` is 0 and the transmitter sends 0xBC with `tx_k`=1.
- R2: The transmit side depends on `phase`. In phase 0 it sends 0xBC with `tx_k`=1. In phase 1 it sends 0x1C with `tx_k`=1. In phase 2 it sends `usr_data` with `tx_k`=0. `link_up` is 1 exactly when `phase` is 2.
- R3: In phase 0, the block moves to phase 1 on the clock edge that accepts the RUN_LEN-th consecutive received K28.5 (0xBC, K-flag 1). After only RUN_LEN-1 such symbols it stays in phase 0.
- R4: A symbol counts as a match only when both the byte and the K-flag match. A received 0xBC with the K-flag 0 breaks a K28.5 run.
- R5: In phase 0, any received symbol other than K28.5 clears the run count, and the block stays in phase 0.
- R6: Cycles with `rx_valid`=0 neither advance nor break a run, whatever is on `rx_data` and `rx_k`.
- R7: In phase 1, the block moves to phase 2 (link up) on the edge that accepts the RUN_LEN-th consecutive received K28.0 (0x1C, K-flag 1).
- R8: In phase 1, a received K28.5 clears the K28.0 run count, and the block stays in phase 1.
- R9: In phase 1, a received symbol that is neither K28.5 nor K28.0 returns the block to phase 0 with the count cleared.
- R10: When `los` is high at a clock edge, the block is in phase 0 after that edge, from any phase, with the count cleared.
- R11: In phase 2, with `los` low, the block stays in phase 2 whatever is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Received symbol present this cycle |
| rx_data | input | 8 | Received byte |
| rx_k | input | 1 | Received control flag |
| los | input | 1 | Loss of sync, forces retraining |
| usr_data | input | 8 | User byte sent once the link is up |
| tx_data | output | 8 | Byte to the transmitter |
| tx_k | output | 1 | Control flag to the transmitter |
| link_up | output | 1 | Training complete |
| phase | output | 2 | 0 comma search, 1 second-character search, 2 link up |

## Verification
The run counter cannot be seen directly. A wrong count therefore shows up only as a phase change at the wrong time. The bench drives runs of RUN_LEN-1 and RUN_LEN symbols, and runs broken at chosen points. It checks `phase` the cycle after each accepted symbol, so an early or late advance is caught on the edge where it happens. A wrong phase register is seen within one cycle on `tx_data`/`tx_k`, because the transmit character follows the phase directly.

// File: rtl/lt_pkg.sv
package lt_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] SYM_K28_5 = 8'hBC;
    localparam logic [BYTE_W-1:0] SYM_K28_0 = 8'h1C;

    typedef enum logic [1:0] {
        PH_COMMA = 2'd0,
        PH_FILL  = 2'd1,
        PH_UP    = 2'd2
    } phase_e;

    typedef struct packed {
        logic              valid;
        logic              k;
        logic [BYTE_W-1:0] data;
    } rx_sym_t;

    typedef struct packed {
        logic hit_comma;
        logic hit_fill;
        logic other;
    } sym_class_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              k;
    } tx_sym_t;

    function automatic logic is_ctrl(input rx_sym_t s, input logic [BYTE_W-1:0] code);
        return s.valid && s.k && (s.data == code);
    endfunction

endpackage

// File: rtl/lt_classify.sv
module lt_classify
    import lt_pkg::*;
(
    input  rx_sym_t    sym,
    output sym_class_t cls
);
    always_comb begin
        cls.hit_comma = is_ctrl(sym, SYM_K28_5);
        cls.hit_fill  = is_ctrl(sym, SYM_K28_0);
        cls.other     = sym.valid && !cls.hit_comma && !cls.hit_fill;
    end
endmodule

// File: rtl/lt_run_counter.sv
module lt_run_counter #(
    parameter int RUN_LEN = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(RUN_LEN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == LAST_VAL);
endmodule

// File: rtl/lt_tx_sel.sv
module lt_tx_sel
    import lt_pkg::*;
(
    input  phase_e            ph,
    input  logic [BYTE_W-1:0] usr_data,
    output tx_sym_t           tx
);
    always_comb begin
        unique case (ph)
            PH_COMMA: tx = '{data: SYM_K28_5, k: 1'b1};
            PH_FILL:  tx = '{data: SYM_K28_0, k: 1'b1};
            PH_UP:    tx = '{data: usr_data,  k: 1'b0};
            default:  tx = '{data: SYM_K28_5, k: 1'b1};
        endcase
    end
endmodule

// File: rtl/link_trainer.sv
module link_trainer
    import lt_pkg::*;
#(
    parameter int RUN_LEN = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_k,
    input  logic        los,
    input  logic [7:0]  usr_data,
    output logic [7:0]  tx_data,
    output logic        tx_k,
    output logic        link_up,
    output logic [1:0]  phase
);
    rx_sym_t    sym;
    sym_class_t cls;
    tx_sym_t    tx;
    phase_e     ph_q, ph_d;
    logic       cnt_clr, cnt_inc, cnt_last;

    assign sym = '{valid: rx_valid, k: rx_k, data: rx_data};

    lt_classify u_cls (
        .sym (sym),
        .cls (cls)
    );

    lt_run_counter #(.RUN_LEN(RUN_LEN)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (cnt_clr),
        .inc  (cnt_inc),
        .last (cnt_last)
    );

    always_comb begin
        ph_d    = ph_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        if (los) begin
            ph_d    = PH_COMMA;
            cnt_clr = 1'b1;
        end else begin
            unique case (ph_q)
                PH_COMMA: begin
                    if (cls.hit_comma) begin
                        if (cnt_last) begin
                            ph_d    = PH_FILL;
                            cnt_clr = 1'b1;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end else if (cls.other || cls.hit_fill) begin
                        cnt_clr = 1'b1;
                    end
                end
                PH_FILL: begin
                    if (cls.hit_fill) begin
                        if (cnt_last) begin
                            ph_d    = PH_UP;
                            cnt_clr = 1'b1;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end else if (cls.hit_comma) begin
                        cnt_clr = 1'b1;
                    end else if (cls.other) begin
                        ph_d    = PH_COMMA;
                        cnt_clr = 1'b1;
                    end
                end
                PH_UP: begin
                    cnt_clr = 1'b1;
                end
                default: begin
                    ph_d    = PH_COMMA;
                    cnt_clr = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_COMMA;
        end else begin
            ph_q <= ph_d;
        end
    end

    lt_tx_sel u_tx (
        .ph       (ph_q),
        .usr_data (usr_data),
        .tx       (tx)
    );

    assign tx_data = tx.data;
    assign tx_k    = tx.k;
    assign link_up = (ph_q == PH_UP);
    assign phase   = ph_q;
endmodule

// File: rtl/lt_checker.sv
module lt_checker (
    input logic       clk,
    input logic       rst,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       rx_k,
    input logic       los,
    input logic [7:0] usr_data,
    input logic [7:0] tx_data,
    input logic       tx_k,
    input logic       link_up,
    input logic [1:0] phase
);
    logic rx_comma, rx_fill;
    assign rx_comma = rx_valid && rx_k && (rx_data == 8'hBC);
    assign rx_fill  = rx_valid && rx_k && (rx_data == 8'h1C);

    AST_LOS_RETURN: assert property (@(posedge clk) disable iff (rst)
        los |=> (phase == 2'd0)); // R10

    AST_UP_STICKY: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd2) && !los |=> (phase == 2'd2)); // R11

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rx_valid && !los |=> $stable(phase)); // R6

    AST_NO_SKIP: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd0) |=> (phase != 2'd2)); // R3

    AST_NEED_KFLAG: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd0) && !rx_comma |=> (phase == 2'd0)); // R4

    AST_FILL_KEEP: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd1) && !los && (rx_comma || rx_fill) |=> (phase != 2'd0)); // R8

    AST_FILL_DROP: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd1) && rx_valid && !rx_comma && !rx_fill |=> (phase == 2'd0)); // R9

    AST_TX_USER: assert property (@(posedge clk) disable iff (rst)
        link_up |-> (!tx_k && tx_data == usr_data)); // R2

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        phase != 2'd3); // R2
endmodule

bind link_trainer lt_checker u_chk (.*);

// File: tb/sim_link_trainer.sv
module sim_link_trainer;
    localparam int CLK_PERIOD = 10;
    localparam int RUN = 256;

    logic       clk = 1'b0;
    logic       rst;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_k;
    logic       los;
    logic [7:0] usr_data;
    logic [7:0] tx_data;
    logic       tx_k;
    logic       link_up;
    logic [1:0] phase;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_ph;
    int m_cnt;

    always #(CLK_PERIOD / 2) clk = ~clk;

    link_trainer #(.RUN_LEN(RUN)) u0 (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_k(rx_k),
        .los(los), .usr_data(usr_data), .tx_data(tx_data), .tx_k(tx_k),
        .link_up(link_up), .phase(phase)
    );

    function automatic logic [7:0] exp_txd(int ph, logic [7:0] u);
        return (ph == 0) ? 8'hBC : (ph == 1) ? 8'h1C : u;
    endfunction

    function automatic logic exp_txk(int ph);
        return (ph != 2);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model(logic v, logic [7:0] d, logic k, logic l);
        logic a, b;
        a = v && k && d == 8'hBC;
        b = v && k && d == 8'h1C;
        if (l) begin
            m_ph = 0; m_cnt = 0;
        end else if (v) begin
            if (m_ph == 0) begin
                if (a) begin
                    if (m_cnt == RUN - 1) begin m_ph = 1; m_cnt = 0; end
                    else m_cnt++;
                end else m_cnt = 0;
            end else if (m_ph == 1) begin
                if (b) begin
                    if (m_cnt == RUN - 1) begin m_ph = 2; m_cnt = 0; end
                    else m_cnt++;
                end else if (a) m_cnt = 0;
                else begin m_ph = 0; m_cnt = 0; end
            end
        end
    endtask

    task automatic step(logic v, logic [7:0] d, logic k, logic l, string tag);
        @(negedge clk);
        rx_valid = v; rx_data = d; rx_k = k; los = l;
        usr_data = 8'($urandom);
        @(posedge clk);
        model(v, d, k, l);
        #1;
        chk(tag, "phase", int'(phase), m_ph);
        chk(tag, "link_up", int'(link_up), int'(m_ph == 2));
        chk("R2", "tx_data", int'(tx_data), int'(exp_txd(m_ph, usr_data)));
        chk("R2", "tx_k", int'(tx_k), int'(exp_txk(m_ph)));
    endtask

    task automatic burst(int n, logic [7:0] d, logic k, string tag);
        for (int i = 0; i < n; i++) step(1'b1, d, k, 1'b0, tag);
    endtask

    task automatic expect_phase(string tag, int ph);
        chk(tag, "phase point", int'(phase), ph);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        rst = 1'b1; rx_valid = 0; rx_data = 0; rx_k = 0; los = 0; usr_data = 8'h5A;
        m_ph = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", "phase", int'(phase), 0);
        chk("R1", "link_up", int'(link_up), 0);
        chk("R1", "tx_data", int'(tx_data), 8'hBC);
        chk("R1", "tx_k", int'(tx_k), 1);

        // R5 break with a data byte
        burst(100, 8'hBC, 1'b1, "R5");
        step(1'b1, 8'h55, 1'b0, 1'b0, "R5");
        burst(RUN - 1, 8'hBC, 1'b1, "R5");
        expect_phase("R5", 0);
        // R4 0xBC without K-flag breaks the run
        step(1'b1, 8'hBC, 1'b0, 1'b0, "R4");
        burst(RUN - 1, 8'hBC, 1'b1, "R4");
        expect_phase("R4", 0);
        // R6 idle cycles carrying garbage do not break the run
        for (int i = 0; i < 20; i++) step(1'b0, 8'h3C, 1'b1, 1'b0, "R6");
        expect_phase("R6", 0);
        // R3 final symbol completes the run
        step(1'b1, 8'hBC, 1'b1, 1'b0, "R3");
        expect_phase("R3", 1);

        // R8 K28.5 restarts the second run
        burst(200, 8'h1C, 1'b1, "R8");
        step(1'b1, 8'hBC, 1'b1, 1'b0, "R8");
        burst(RUN - 1, 8'h1C, 1'b1, "R8");
        expect_phase("R8", 1);
        // R7 last K28.0 brings link up
        step(1'b1, 8'h1C, 1'b1, 1'b0, "R7");
        expect_phase("R7", 2);

        // R11 stays up on any traffic
        for (int i = 0; i < 50; i++) step(1'b1, 8'($urandom), 1'($urandom), 1'b0, "R11");
        expect_phase("R11", 2);
        // R10 loss of sync from phase 2
        step(1'b1, 8'h1C, 1'b1, 1'b1, "R10");
        expect_phase("R10", 0);

        // R9 foreign control symbol in phase 1
        burst(RUN, 8'hBC, 1'b1, "R3");
        expect_phase("R3", 1);
        burst(10, 8'h1C, 1'b1, "R9");
        step(1'b1, 8'h3C, 1'b1, 1'b0, "R9");
        expect_phase("R9", 0);
        // R10 loss of sync from phase 1
        burst(RUN, 8'hBC, 1'b1, "R10");
        step(1'b1, 8'h1C, 1'b1, 1'b1, "R10");
        expect_phase("R10", 0);

        // random bursts mixing all symbol kinds, idles and loss of sync
        for (int b = 0; b < 60; b++) begin
            int sel = $urandom_range(0, 9);
            int n   = (sel < 7) ? $urandom_range(RUN - 5, RUN + 5) : $urandom_range(1, 20);
            logic [7:0] d;
            logic k;
            if (sel < 4) begin d = 8'hBC; k = 1'b1; end
            else if (sel < 7) begin d = 8'h1C; k = 1'b1; end
            else begin d = 8'($urandom); k = 1'($urandom); end
            for (int i = 0; i < n; i++) begin
                step($urandom_range(0, 19) != 0, d, k, $urandom_range(0, 999) == 0, "R6");
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule